// File: doc/BRIEF.md
# Attribute-Driven Data Cache Controller

This block is a small direct-mapped data cache that sits between a processor load/store port and a single-beat memory port. Every request carries its own storage attributes. A write-through flag chooses the write policy and whether a write miss allocates a line. A cacheability flag decides whether the access uses the cache or goes straight to memory. A mode flag says whether the access is translated. In untranslated mode the cacheability decision does not come from the request. It comes from a 32-bit region map input: each bit covers one of 32 equal address regions, chosen by the top five address bits. A set bit there means cacheable, the opposite sense from the per-request flag.

The cache holds 16 lines of one 32-bit word each, with a tag, a valid bit and a dirty bit per line. When an allocating miss finds a dirty line in its slot, the controller writes that line back before it reads the new word from memory (read miss) or stores the new word into the line (write miss). Requests use a valid/ready handshake, and only one is in flight at a time. Each accepted request produces exactly one single-cycle response pulse. The memory port holds each transfer until it is acknowledged, with any number of wait cycles. A coherency attribute input is accepted and ignored.

A non-cacheable access to a word that is resident in the cache gives undefined results. Users must not issue one.

Top module: `attr_dcache`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid and mem_valid are 0. Every line is invalid, so the first cacheable read to any address causes one memory read.
- R2: A cacheable write hit with req_wt=0 updates only the line and marks it dirty. It causes no memory transfer, and a later read of that address returns the new data.
- R3: A cacheable write miss with req_wt=0 allocates the line with the write data and marks it dirty. It performs no memory read or write, apart from any victim write-back required by R9.
- R4: A cacheable write hit with req_wt=1 updates the line and also performs one memory write of the same address and data. The line is left clean.
- R5: A cacheable write miss with req_wt=1 performs one memory write and does not allocate. A later read of that address misses and reads memory.
- R6: With req_virt=1, an access is cacheable when req_ci=0. With req_ci=1 it is a single memory transfer of the request's own type, address and data, and the cache is not touched.
- R7: With req_virt=0, cacheability is cache_map[req_addr[31:27]]: 1 means cacheable, 0 means bypass as in R6. req_ci is ignored in this mode.
- R8: req_coh has no effect on any response or memory transfer.
- R9: An allocating miss whose slot holds a valid dirty line first writes that line to memory, at address {old tag, index, 2'b00}. The fill read or the merge follows. A clean or invalid victim is not written.
- R10: req_ready is high only when the controller is idle. Every accepted request produces exactly one resp_valid pulse, one cycle long. mem_valid, mem_addr and mem_write stay steady until mem_ack.
- R11: A cacheable read hit returns the line's data with no memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | 32 | Byte address; bits [5:2] are the index, bits [31:6] are the tag |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_virt | input | 1 | 1 = translated mode, 0 = untranslated mode |
| req_wt | input | 1 | Write-through attribute (1 = write-through, 0 = write-back) |
| req_ci | input | 1 | Cache-inhibit attribute, used in translated mode only |
| req_coh | input | 1 | Coherency attribute, ignored |
| cache_map | input | 32 | Untranslated-mode cacheability, one bit per region, indexed by req_addr[31:27] |
| resp_valid | output | 1 | One-cycle pulse when a request completes |
| resp_rdata | output | 32 | Read data, valid with resp_valid on a read |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
A wrong tag or valid bit shows up as a wrong hit decision on the next access to that index. The symptom is either a memory transfer where none was due, or stale read data in a response. A lost or spurious dirty bit stays hidden until that slot is evicted, and then shows as a missing write-back or an extra one. The bench therefore compares every memory transfer, in order, against a model of the requirements. It revisits each index under both write policies, so that such faults come to the ports within a few requests. A flipped cacheability decision appears immediately, as a missing or extra transfer on the memory port.

// File: rtl/attr_dcache.sv
module attr_dcache #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINES = 16,
  parameter int REGIONS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_virt,
  input  logic          req_wt,
  input  logic          req_ci,
  input  logic          req_coh,
  input  logic [REGIONS-1:0] cache_map,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW - 2;
  localparam int RW = $clog2(REGIONS);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_EVICT, S_MEM, S_RESP} st_t;
  st_t st;

  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q, rd_q;
  logic wr_q, wt_q, cach_q;
  logic [TW-1:0] tag_r [LINES];
  logic [DW-1:0] data_r [LINES];
  logic [LINES-1:0] valid_r, dirty_r;

  logic unused_coh;
  assign unused_coh = req_coh;

  wire [IW-1:0] idx = a_q[IW+1:2];
  wire [TW-1:0] tg  = a_q[AW-1:IW+2];
  wire hit    = valid_r[idx] && (tag_r[idx] == tg);
  wire vdirty = valid_r[idx] && dirty_r[idx];
  wire cach_in = req_virt ? ~req_ci : cache_map[req_addr[AW-1 -: RW]];

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_rdata = rd_q;
  assign mem_valid  = (st == S_EVICT) || (st == S_MEM);
  assign mem_write  = (st == S_EVICT) ? 1'b1 : wr_q;
  assign mem_addr   = (st == S_EVICT) ? {tag_r[idx], idx, 2'b00} : a_q;
  assign mem_wdata  = (st == S_EVICT) ? data_r[idx] : d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_q <= '0; d_q <= '0; rd_q <= '0;
      wr_q <= 1'b0; wt_q <= 1'b0; cach_q <= 1'b0;
      valid_r <= '0; dirty_r <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_r[i] <= '0;
        data_r[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr; d_q <= req_wdata; wr_q <= req_write;
          wt_q <= req_wt; cach_q <= cach_in;
          st <= S_LOOK;
        end
        S_LOOK: begin
          if (!cach_q) st <= S_MEM;
          else if (hit) begin
            if (wr_q) begin
              data_r[idx] <= d_q;
              dirty_r[idx] <= ~wt_q;
              st <= wt_q ? S_MEM : S_RESP;
            end else begin
              rd_q <= data_r[idx];
              st <= S_RESP;
            end
          end
          else if (wr_q && wt_q) st <= S_MEM;
          else if (vdirty) st <= S_EVICT;
          else if (wr_q) begin
            valid_r[idx] <= 1'b1; tag_r[idx] <= tg;
            data_r[idx] <= d_q; dirty_r[idx] <= 1'b1;
            st <= S_RESP;
          end
          else st <= S_MEM;
        end
        S_EVICT: if (mem_ack) begin
          if (wr_q) begin
            tag_r[idx] <= tg; data_r[idx] <= d_q; dirty_r[idx] <= 1'b1;
            st <= S_RESP;
          end else begin
            dirty_r[idx] <= 1'b0;
            st <= S_MEM;
          end
        end
        S_MEM: if (mem_ack) begin
          if (!wr_q) begin
            rd_q <= mem_rdata;
            if (cach_q) begin
              valid_r[idx] <= 1'b1; tag_r[idx] <= tg;
              data_r[idx] <= mem_rdata; dirty_r[idx] <= 1'b0;
            end
          end
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/attr_dcache_chk.sv
module attr_dcache_chk #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_virt,
  input logic          req_ci,
  input logic [(1<<RW)-1:0] cache_map,
  input logic          resp_valid,
  input logic          mem_valid,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_write
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !resp_valid)); // R1
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R10
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready)); // R10
  AST_VIRT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_virt && req_ci) |=> ##1 (mem_valid && mem_addr == $past(req_addr, 2))); // R6
  AST_REAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_virt && !cache_map[req_addr[AW-1 -: RW]])
      |=> ##1 (mem_valid && mem_addr == $past(req_addr, 2))); // R7
endmodule

bind attr_dcache attr_dcache_chk #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/attr_dcache_test.sv
module attr_dcache_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_virt = 0, req_wt = 0, req_ci = 0, req_coh = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, cache_map = 32'h0000_00FF;
  logic req_ready, resp_valid, mem_valid, mem_write;
  logic [31:0] resp_rdata, mem_addr, mem_wdata;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;

  always #10 clk = ~clk;

  attr_dcache uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic        exp_rd_q[$];
  logic [31:0] exp_dat_q[$];
  string       exp_rq_q[$];
  logic        xm_wr_q[$];
  logic [31:0] xm_a_q[$], xm_d_q[$];
  string       xm_rq_q[$];

  logic [31:0] mem_arr [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  logic        rv [16];
  logic        rdt [16];
  logic [25:0] rt [16];
  logic [31:0] rdat [16];

  function automatic logic [31:0] memdef(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : memdef(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic push_mem(input logic w, input logic [31:0] a, input logic [31:0] d, input string rq);
    xm_wr_q.push_back(w); xm_a_q.push_back(a); xm_d_q.push_back(d); xm_rq_q.push_back(rq);
  endtask

  task automatic acc(input logic [31:0] a, input logic wr, input logic [31:0] d,
                     input logic virt, input logic wt, input logic ci, input logic coh, input string rq);
    logic [3:0] ix; logic [25:0] tg; logic c; logic [31:0] ex, va;
    ix = a[5:2]; tg = a[31:6]; ex = 0;
    c = virt ? !ci : cache_map[a[31:27]];
    if (!c) begin
      push_mem(wr, a, d, rq);
      if (wr) ref_mem[a] = d; else ex = ref_rd(a);
    end else if (rv[ix] && rt[ix] == tg) begin
      if (wr) begin
        rdat[ix] = d;
        if (wt) begin push_mem(1, a, d, rq); ref_mem[a] = d; rdt[ix] = 0; end
        else rdt[ix] = 1;
      end else ex = rdat[ix];
    end else if (wr && wt) begin
      push_mem(1, a, d, rq); ref_mem[a] = d;
    end else begin
      if (rv[ix] && rdt[ix]) begin
        va = {rt[ix], ix, 2'b00};
        push_mem(1, va, rdat[ix], rq); ref_mem[va] = rdat[ix];
      end
      rv[ix] = 1; rt[ix] = tg;
      if (wr) begin rdat[ix] = d; rdt[ix] = 1; end
      else begin push_mem(0, a, 0, rq); rdat[ix] = ref_rd(a); rdt[ix] = 0; ex = rdat[ix]; end
    end
    exp_rd_q.push_back(!wr); exp_dat_q.push_back(ex); exp_rq_q.push_back(rq);
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = d; req_virt = virt;
    req_wt = wt; req_ci = ci; req_coh = coh; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_rd_q.size() == 0) chk(0, "R10 unexpected response", resp_rdata, 0);
      else begin
        logic r; logic [31:0] e; string q;
        r = exp_rd_q.pop_front(); e = exp_dat_q.pop_front(); q = exp_rq_q.pop_front();
        if (r) chk(resp_rdata === e, q, resp_rdata, e);
        else chk(1, q, 0, 0);
      end
    end
  end

  int wcnt = 0, pat = 0;
  always @(negedge clk) begin
    if (!rst_n) mem_ack = 0;
    else if (mem_ack) mem_ack = 0;
    else if (mem_valid) begin
      if (wcnt > 0) wcnt--;
      else begin
        if (xm_wr_q.size() == 0) chk(0, "R10 unexpected memory transfer", mem_addr, 0);
        else begin
          logic w; logic [31:0] a, d; string q;
          w = xm_wr_q.pop_front(); a = xm_a_q.pop_front(); d = xm_d_q.pop_front(); q = xm_rq_q.pop_front();
          chk(mem_write === w, {q, " mem_write"}, {31'b0, mem_write}, {31'b0, w});
          chk(mem_addr === a, {q, " mem_addr"}, mem_addr, a);
          if (w) chk(mem_wdata === d, {q, " mem_wdata"}, mem_wdata, d);
        end
        if (mem_write) mem_arr[mem_addr] = mem_wdata;
        else mem_rdata = mem_arr.exists(mem_addr) ? mem_arr[mem_addr] : memdef(mem_addr);
        mem_ack = 1;
        pat++;
        wcnt = pat % 4;
      end
    end
  end

  initial begin
    logic [31:0] s, a, low;
    for (int i = 0; i < 16; i++) begin rv[i] = 0; rdt[i] = 0; rt[i] = 0; rdat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", {31'b0, req_ready}, 1);
    chk(resp_valid === 1'b0, "R1 no response after reset", {31'b0, resp_valid}, 0);
    chk(mem_valid === 1'b0, "R1 memory quiet after reset", {31'b0, mem_valid}, 0);

    acc(32'h0000_0010, 0, 0, 1, 0, 0, 0, "R1 first read misses");
    acc(32'h0000_0010, 0, 0, 1, 0, 0, 0, "R11 read hit");
    acc(32'h0000_0010, 1, 32'hAAAA_0001, 1, 0, 0, 0, "R2 write-back hit");
    acc(32'h0000_0010, 0, 0, 1, 0, 0, 0, "R2 read after write-back hit");
    acc(32'h0000_0050, 1, 32'hBBBB_0002, 1, 0, 0, 0, "R3 R9 write-back miss evicts dirty");
    acc(32'h0000_0050, 0, 0, 1, 0, 0, 0, "R3 read of allocated line");
    acc(32'h0000_0010, 0, 0, 1, 0, 0, 0, "R9 read miss evicts dirty then fills");
    acc(32'h0000_0010, 1, 32'hCCCC_0003, 1, 1, 0, 0, "R4 write-through hit");
    acc(32'h0000_0010, 0, 0, 1, 0, 0, 0, "R4 read after write-through hit");
    acc(32'h0000_0050, 0, 0, 1, 0, 0, 0, "R9 clean victim not written");
    acc(32'h0000_0024, 1, 32'hDDDD_0004, 1, 1, 0, 0, "R5 write-through miss");
    acc(32'h0000_0024, 0, 0, 1, 0, 0, 0, "R5 no allocation on write-through miss");
    acc(32'hF000_0100, 0, 0, 1, 0, 1, 0, "R6 inhibited read bypass");
    acc(32'hF000_0100, 1, 32'hEEEE_0005, 1, 0, 1, 0, "R6 inhibited write bypass");
    acc(32'hF000_0100, 0, 0, 1, 0, 1, 0, "R6 inhibited read sees memory");
    acc(32'h0800_0030, 0, 0, 0, 0, 1, 0, "R7 untranslated set bit caches");
    acc(32'h0800_0030, 0, 0, 0, 0, 1, 0, "R7 untranslated hit");
    acc(32'h4000_0040, 0, 0, 0, 0, 0, 0, "R7 untranslated clear bit bypasses");
    acc(32'h4000_0040, 0, 0, 0, 0, 0, 0, "R7 untranslated bypass again");
    acc(32'h0000_0070, 1, 32'h1234_5678, 1, 0, 0, 1, "R8 coherency set on write");
    acc(32'h0000_0070, 0, 0, 1, 0, 0, 1, "R8 coherency set on read");

    s = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      low = {22'h0, s[11:8], s[5:2], 2'b00};
      case (s[17:16])
        2'd0: a = low;
        2'd1: a = 32'h1000_0000 | low;
        2'd2: a = 32'hF800_0000 | low;
        default: a = 32'h4800_0000 | low;
      endcase
      case (s[17:16])
        2'd0: acc(a, s[12], s ^ 32'h0F0F_0F0F, 1, s[13], 0, s[14], "R2 R3 R4 R5 R9 mixed translated");
        2'd1: acc(a, s[12], s ^ 32'h0F0F_0F0F, 0, s[13], s[15], s[14], "R7 R8 mixed untranslated");
        2'd2: acc(a, s[12], s ^ 32'h0F0F_0F0F, 1, s[13], 1, s[14], "R6 mixed bypass");
        default: acc(a, s[12], s ^ 32'h0F0F_0F0F, 0, s[13], s[15], s[14], "R7 mixed region bypass");
      endcase
    end

    for (int i = 0; i < 200; i++) begin
      if (exp_rd_q.size() == 0 && req_ready) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(exp_rd_q.size() == 0, "R10 all responses seen", exp_rd_q.size(), 0);
    chk(xm_wr_q.size() == 0, "R10 all memory transfers seen", xm_wr_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule